// File: doc/BRIEF.md
# Latching Interrupt Controller

This block collects up to 32 interrupt request lines for a small processor core and turns them into a single request. Each line has one bit in a mask register and one bit in a status register, and both registers sit on a simple special-register port. Each input passes through a two-flop synchronizer. On edge lines a rising transition sets the status bit, and the bit then stays set until software clears it. A build parameter picks, line by line, whether a line is edge or level.

The clear convention is a build-time choice. In the standard convention, software writes a 1 to a status bit to clear it, and level lines are not latched: their status bit simply mirrors the synchronized input. In the alternate convention, level lines are latched as well. Software clears a status bit by writing 0 to it, so it does a read-modify-write of the status register.

The core receives one registered request. That request is the OR of all unmasked pending lines, gated by a global enable input. A combinational encoder reports the lowest-numbered unmasked pending line, so an interrupt handler can scan upward from line zero.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the mask register reads 0, the status register reads 0, `irq_out` is 0 and `pend_valid` is 0.
- R2: A write with `reg_addr` 0 replaces the mask register, and a read with `reg_addr` 0 returns it. `reg_addr` 1 selects the status register. Addresses 2 and 3 read as 0, and writes to them change nothing. Reads have no side effects.
- R3: On an edge line (bit of `LEVEL_MASK` = 0), a rising transition of the synchronized input sets the status bit. The bit then stays set until it is cleared by a write.
- R4: With `CLR_MODE` = 0 (standard), writing 1 to the status bit of an edge line clears it, and writing 0 leaves it unchanged. On a level line (bit of `LEVEL_MASK` = 1), the status bit follows the synchronized input and status writes have no effect on it.
- R5: With `CLR_MODE` = 1 (alternate), every line is latched. A level line is set in every cycle its synchronized input is high. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.
- R6: If a line's set event and a clear write of that line fall in the same cycle, the status bit ends up set.
- R7: `pend_valid` is 1 exactly when (status AND mask) is non-zero. When it is 1, `pend_idx` is the lowest index set in (status AND mask).
- R8: `irq_out` equals the value of `gie` AND (OR over status AND mask) one clock earlier.
- R9: A line whose mask bit is 0 still latches in the status register, but it does not raise `irq_out` or `pend_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Raw interrupt request lines |
| gie | input | 1 | Global interrupt enable from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 mask, 1 status) |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Registered combined request to the core |
| pend_valid | output | 1 | Some unmasked line is pending |
| pend_idx | output | IDX_W | Lowest unmasked pending line |

## Verification
The assertions assume that `rst_n` is held low long enough for the synchronizer flops to settle to 0. They also assume `reg_wr` is a single-cycle strobe whose address and data are stable at the sampling edge. The bench drives every input only on falling edges. It holds each input pattern for four cycles, so every transition passes the synchronizer before the next one arrives. The only exception is one directed case, which deliberately lines up a synchronized edge with a clear write in the same cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  // register selects on the special-register port
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } reg_sel_e;

  // clear convention of the status latches
  typedef enum bit {
    CLR_BY_ONE  = 1'b0,  // write 1 clears, level lines transparent
    CLR_BY_ZERO = 1'b1   // write 0 clears, level lines latched
  } clr_mode_e;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_in,
  output logic [N_LINES-1:0] sync_lvl,
  output logic [N_LINES-1:0] rise_pulse
);

  logic [N_LINES-1:0] meta_q;
  logic [N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] hist_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        hist_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= raw_in[g];
        sync_q[g] <= meta_q[g];
        hist_q[g] <= sync_q[g];
      end
    end
    assign rise_pulse[g] = sync_q[g] & ~hist_q[g];
  end

  assign sync_lvl = sync_q;

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_latch_pkg::*;
#(
  parameter int                N_LINES    = 32,
  parameter logic [N_LINES-1:0] LEVEL_MASK = '0,
  parameter clr_mode_e         CLR_MODE   = CLR_BY_ONE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] sync_lvl,
  input  logic [N_LINES-1:0] rise_pulse,
  input  logic               wr_stat,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] set_vec,
  output logic [N_LINES-1:0] clr_vec,
  output logic [N_LINES-1:0] stat_q
);

  localparam logic [N_LINES-1:0] LATCHED =
    (CLR_MODE == CLR_BY_ZERO) ? {N_LINES{1'b1}} : ~LEVEL_MASK;

  // which bits a status write asks to clear, per convention
  function automatic logic [N_LINES-1:0] clear_bits(input logic we,
                                                    input logic [N_LINES-1:0] d);
    if (!we) return '0;
    return (CLR_MODE == CLR_BY_ZERO) ? ~d : d;
  endfunction

  // which bits raise their latch this cycle
  function automatic logic [N_LINES-1:0] set_bits(input logic [N_LINES-1:0] lvl,
                                                  input logic [N_LINES-1:0] rise);
    logic [N_LINES-1:0] s;
    s = rise & ~LEVEL_MASK;
    if (CLR_MODE == CLR_BY_ZERO) s = s | (lvl & LEVEL_MASK);
    return s;
  endfunction

  // set has priority over clear
  function automatic logic next_latch(input logic cur, input logic s, input logic c);
    return s | (cur & ~c);
  endfunction

  assign set_vec = set_bits(sync_lvl, rise_pulse);
  assign clr_vec = clear_bits(wr_stat, wdata);

  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    if (LATCHED[g]) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[g] <= 1'b0;
        else        stat_q[g] <= next_latch(stat_q[g], set_vec[g], clr_vec[g]);
      end
    end else begin : g_follow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[g] <= 1'b0;
        else        stat_q[g] <= sync_lvl[g];
      end
    end
  end

endmodule

// File: rtl/irq_low_enc.sv
module irq_low_enc #(
  parameter int N_LINES = 32,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] bits_in,
  output logic               any_set,
  output logic [IDX_W-1:0]   low_idx
);

  function automatic logic [IDX_W-1:0] lowest_one(input logic [N_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any_set = |bits_in;
  assign low_idx = lowest_one(bits_in);

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES    = 32,
  parameter logic [N_LINES-1:0] LEVEL_MASK = 32'h0000_FF00,
  parameter clr_mode_e          CLR_MODE   = CLR_BY_ONE,
  localparam int                IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               gie,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_out,
  output logic               pend_valid,
  output logic [IDX_W-1:0]   pend_idx
);

  reg_sel_e           sel;
  logic               wr_mask;
  logic               wr_stat;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] stat_q;
  logic [N_LINES-1:0] sync_lvl;
  logic [N_LINES-1:0] rise_pulse;
  logic [N_LINES-1:0] set_vec;
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] live_vec;
  logic               any_live;
  logic               irq_q;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_mask = reg_wr && (sel == SEL_MASK);
  assign wr_stat = reg_wr && (sel == SEL_STAT);

  irq_line_sync #(.N_LINES(N_LINES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (irq_in),
    .sync_lvl   (sync_lvl),
    .rise_pulse (rise_pulse)
  );

  irq_stat_bank #(
    .N_LINES    (N_LINES),
    .LEVEL_MASK (LEVEL_MASK),
    .CLR_MODE   (CLR_MODE)
  ) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl   (sync_lvl),
    .rise_pulse (rise_pulse),
    .wr_stat    (wr_stat),
    .wdata      (reg_wdata),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .stat_q     (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  assign live_vec = stat_q & mask_q;

  irq_low_enc #(.N_LINES(N_LINES)) u_enc (
    .bits_in (live_vec),
    .any_set (any_live),
    .low_idx (pend_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie & any_live;
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata = mask_q;
      SEL_STAT: reg_rdata = stat_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_out    = irq_q;
  assign pend_valid = any_live;

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES    = 32,
  parameter logic [N_LINES-1:0] LEVEL_MASK = '0,
  parameter clr_mode_e          CLR_MODE   = CLR_BY_ONE,
  localparam int                IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [N_LINES-1:0] reg_wdata,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] stat_q,
  input logic [N_LINES-1:0] set_vec,
  input logic               irq_out,
  input logic               pend_valid,
  input logic [IDX_W-1:0]   pend_idx
);

  localparam logic [N_LINES-1:0] LATCHED =
    (CLR_MODE == CLR_BY_ZERO) ? {N_LINES{1'b1}} : ~LEVEL_MASK;

  logic [N_LINES-1:0] live_bits;
  logic [N_LINES-1:0] below_idx;
  logic [N_LINES-1:0] set_lat;
  logic               mask_wr;
  logic               stat_wr;

  assign live_bits = stat_q & mask_q;
  assign below_idx = (N_LINES'(1) << pend_idx) - N_LINES'(1);
  assign set_lat   = set_vec & LATCHED;
  assign mask_wr   = reg_wr && (reg_addr == 2'd0);
  assign stat_wr   = reg_wr && (reg_addr == 2'd1);

  // R2: a mask write lands on the next edge
  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(reg_wdata)));

  // R2: without a mask write the mask holds
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R3: latched bits hold with no set and no status write
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && (set_lat == '0)) |=> ((stat_q & LATCHED) == ($past(stat_q) & LATCHED)));

  // R6: a set event always leaves its latch set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(set_lat)) == $past(set_lat)));

  // R7: encoder points at a live bit with nothing live below it
  a_r7_enc_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (live_bits[pend_idx] && ((live_bits & below_idx) == '0)));

  a_r7_enc_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (live_bits == '0));

  // R8: request follows enable and live lines one cycle late
  a_r8_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out == $past(gie && (live_bits != '0))));

endmodule

bind irq_latch_ctrl irq_latch_chk #(
  .N_LINES    (N_LINES),
  .LEVEL_MASK (LEVEL_MASK),
  .CLR_MODE   (CLR_MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gie        (gie),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .mask_q     (mask_q),
  .stat_q     (stat_q),
  .set_vec    (set_vec),
  .irq_out    (irq_out),
  .pend_valid (pend_valid),
  .pend_idx   (pend_idx)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  import irq_latch_pkg::*;

  localparam int          N   = 32;
  localparam logic [31:0] LVL = 32'h0000_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        gie = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_std, rd_alt;
  logic        irq_std, irq_alt, pv_std, pv_alt;
  logic [4:0]  pi_std, pi_alt;

  int checks = 0;
  int errors = 0;
  logic [31:0] ex_mask = '0, ex_std = '0, ex_alt = '0, prev_in = '0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.N_LINES(N), .LEVEL_MASK(LVL), .CLR_MODE(CLR_BY_ONE)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .gie(gie), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_std),
    .irq_out(irq_std), .pend_valid(pv_std), .pend_idx(pi_std));

  irq_latch_ctrl #(.N_LINES(N), .LEVEL_MASK(LVL), .CLR_MODE(CLR_BY_ZERO)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .gie(gie), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_alt),
    .irq_out(irq_alt), .pend_valid(pv_alt), .pend_idx(pi_alt));

  function automatic logic [4:0] low_of(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // model of a held input pattern after it passes the synchronizer
  task automatic drive_in(input logic [31:0] v);
    logic [31:0] rise;
    @(negedge clk); irq_in = v;
    repeat (4) @(posedge clk);
    rise    = v & ~prev_in & ~LVL;
    ex_std  = ((ex_std | rise) & ~LVL) | (v & LVL);
    ex_alt  = ex_alt | rise | (v & LVL);
    prev_in = v;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
    if (a == 2'd0) ex_mask = d;
    if (a == 2'd1) begin
      ex_std = ex_std & ~(d & ~LVL);
      ex_alt = (ex_alt & d) | (prev_in & LVL);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] ls, la;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ls = ex_std & ex_mask;
    la = ex_alt & ex_mask;
    reg_addr = 2'd0; #1;
    chk(rd_std, ex_mask, {tag, " R2 mask std"});
    chk(rd_alt, ex_mask, {tag, " R2 mask alt"});
    reg_addr = 2'd1; #1;
    chk(rd_std, ex_std, {tag, " R3/R4 status std"});
    chk(rd_alt, ex_alt, {tag, " R5 status alt"});
    chk(32'(irq_std), 32'(gie & (ls != 0)), {tag, " R8/R9 irq std"});
    chk(32'(irq_alt), 32'(gie & (la != 0)), {tag, " R8/R9 irq alt"});
    chk(32'(pv_std), 32'(ls != 0), {tag, " R7 valid std"});
    chk(32'(pv_alt), 32'(la != 0), {tag, " R7 valid alt"});
    if (ls != 0) chk(32'(pi_std), 32'(low_of(ls)), {tag, " R7 idx std"});
    if (la != 0) chk(32'(pi_alt), 32'(low_of(la)), {tag, " R7 idx alt"});
  endtask

  // edge on line 3 synchronized into the very cycle of a status write
  task automatic coincide(input logic [31:0] d, input string tag);
    logic [31:0] v;
    drive_in(prev_in | 32'h8);
    drive_in(prev_in & ~32'h8);
    v = prev_in | 32'h8;
    @(negedge clk); irq_in = v;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    ex_std  = (ex_std & ~(d & ~LVL)) | 32'h8;
    ex_alt  = (ex_alt & d) | (v & LVL) | 32'h8;
    prev_in = v;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd0; #1;
    chk(rd_std, 32'h0, "R1 mask in reset");
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 2'd0; #1; chk(rd_std, 32'h0, "R1 mask after reset");
    reg_addr = 2'd1; #1; chk(rd_std, 32'h0, "R1 status after reset");
    chk(rd_alt, 32'h0, "R1 status alt after reset");
    chk(32'(irq_std), 0, "R1 irq after reset");
    chk(32'(pv_alt), 0, "R1 pend_valid after reset");

    // R9: masked-off line latches but stays silent
    gie = 1'b1;
    drive_in(32'h0000_0004);
    check_all("R9 masked");

    // R2: mask, reserved addresses, read has no side effect
    write_reg(2'd0, 32'h0000_0F0C);
    check_all("R2 mask");
    write_reg(2'd2, 32'hFFFF_FFFF);
    write_reg(2'd3, 32'h0000_0000);
    @(negedge clk);
    reg_addr = 2'd2; #1; chk(rd_std, 32'h0, "R2 reserved read");
    reg_addr = 2'd1; #1; r = rd_std; #1; chk(rd_std, r, "R2 repeat read");
    check_all("R2 after reserved");

    // R8: one-cycle delay after enable rises
    @(negedge clk); gie = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); gie = 1'b1; #1;
    chk(32'(irq_std), 0, "R8 before edge");
    @(posedge clk); @(negedge clk);
    chk(32'(irq_std), 32'((ex_std & ex_mask) != 0), "R8 one cycle later");

    // R4 / R5 directed: level line 9 and edge line 2
    write_reg(2'd0, 32'hFFFF_FFFF);
    drive_in(32'h0000_0200);
    check_all("R4/R5 level high");
    drive_in(32'h0000_0000);
    check_all("R4/R5 level low");
    write_reg(2'd1, 32'h0000_0204);
    check_all("R4 clear by one");
    write_reg(2'd1, 32'hFFFF_FDFB);
    check_all("R5 clear by zero");

    // R6: coincident set and clear
    coincide(32'h0000_0008, "R6 std");
    coincide(32'hFFFF_FFF7, "R6 alt");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      r = $urandom;
      unique case (r % 5)
        0: drive_in($urandom);
        1: write_reg(2'd0, $urandom);
        2: write_reg(2'd1, $urandom);
        3: write_reg(2'(2 + (r[8] ? 1 : 0)), $urandom);
        default: begin @(negedge clk); gie = ~gie; end
      endcase
      check_all("rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule